// File: doc/BRIEF.md
# Two-Way Translation Buffer with Software Refill

This block keeps a small set of page translations close to the core. A lookup presents a virtual page number with an access kind (read or write) and a privilege mode (user or kernel). One clock later the block reports one of three outcomes: a translation with its physical frame number, a protection fault, or a miss. On a miss it raises a one-cycle interrupt pulse and holds the faulting page number for the handler. The handler walks the page tables itself and loads the entry through the refill port.

The storage is split into sets of two ways. The low bits of the page number pick the set. Both ways are compared in the same cycle, so two pages that share a set can be resident together. A successful access marks the entry as referenced, and a successful write also marks it dirty. A flush input drops every entry in one cycle, for use on a context switch.

Top module: `tlb2w_top`

## Requirements
- R1: When `lk_req_i` is high at a clock edge, exactly one of `hit_o`, `prot_fault_o` and `miss_irq_o` is high after that edge, for one cycle. On a permitted hit, `pfn_o` carries the stored frame number. With no request, all three are low and `pfn_o` is zero.
- R2: The set index is `vpn[IDX_W-1:0]` and the upper bits form the tag. With the default 64 sets, pages 0o621 and 0o321 share set 0o21, and both hit after both are refilled.
- R3: A miss pulses `miss_irq_o` for one cycle and loads `miss_vpn_o` with the requested page. `miss_vpn_o` holds that value until the next miss.
- R4: The flag encoding on `rf_flags_i` is bit0 user-read, bit1 user-write, bit2 kernel-read, bit3 kernel-write, bit4 referenced, bit5 dirty. The permission bit checked is the one for the request's mode and access kind. A hit without that permission raises `prot_fault_o`, and `hit_o` stays low with `pfn_o` zero.
- R5: On a hit or a fault, `ref_o` and `dirty_o` report the entry's stored flags as they were before this access. A permitted hit sets the referenced flag.
- R6: A permitted write hit sets the dirty flag. A read hit leaves it unchanged, and a faulting access changes no flag.
- R7: A refill goes to the way whose valid tag matches, if there is one. Otherwise it goes to the first invalid way (way 0 before way 1). Otherwise it goes to the way named by the set's toggle bit, which resets to 0 and flips only on such an eviction.
- R8: `flush_i` invalidates every entry. A refill in the flush cycle is dropped, and a lookup in the flush cycle misses.
- R9: When a refill and a lookup address the same set in the same cycle, the lookup sees the set as it is after the refill.
- R10: After reset every entry is invalid and all outputs are low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_wr_i | input | 1 | Lookup is a write (1) or read (0) |
| lk_user_i | input | 1 | Lookup in user mode (1) or kernel mode (0) |
| rf_req_i | input | 1 | Refill request |
| rf_vpn_i | input | VPN_W | Refill virtual page number |
| rf_pfn_i | input | PFN_W | Refill physical frame number |
| rf_flags_i | input | 6 | Refill permission and status flags |
| hit_o | output | 1 | Permitted translation this cycle |
| pfn_o | output | PFN_W | Translated frame number |
| prot_fault_o | output | 1 | Entry present but access not allowed |
| ref_o | output | 1 | Entry's referenced flag before the access |
| dirty_o | output | 1 | Entry's dirty flag before the access |
| miss_irq_o | output | 1 | Miss interrupt pulse |
| miss_vpn_o | output | VPN_W | Page number of the most recent miss |

## Verification
A refill and a lookup can fall in the same cycle, and so can a flush and either of them. The bench drives a refill and a lookup to one set on the same edge, both in directed steps and in a long random phase. The random phase uses a small page pool so that collisions in a set, evictions and same-cycle flushes happen often. Each cycle, a behavioural model applies flush, then refill, then the lookup with its flag update. The bench compares every output with that model one clock after each request.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;

  // Flag layout of an entry; ur is bit 0, dirty is bit 5.
  typedef struct packed {
    logic dirty;
    logic refd;
    logic kw;
    logic kr;
    logic uw;
    logic ur;
  } tlb_flags_t;

  localparam int FLAGS_W = 6;

  function automatic logic perm_ok(tlb_flags_t f, logic wr, logic user);
    logic ok;
    case ({user, wr})
      2'b10:   ok = f.ur;
      2'b11:   ok = f.uw;
      2'b00:   ok = f.kr;
      default: ok = f.kw;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb2w_set.sv
module tlb2w_set
  import tlb2w_pkg::*;
#(
  parameter int TAG_W = 14,
  parameter int PFN_W = 42
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic                  wr_en_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  logic [PFN_W-1:0]      wr_pfn_i,
  input  tlb_flags_t            wr_flags_i,
  input  logic                  upd_en_i,
  input  logic                  upd_way_i,
  input  logic                  upd_dirty_i,
  output logic [1:0]            view_v_o,
  output logic [1:0][TAG_W-1:0] view_tag_o,
  output logic [1:0][PFN_W-1:0] view_pfn_o,
  output tlb_flags_t [1:0]      view_flags_o
);

  logic [1:0]            v_q, v_d;
  logic [1:0][TAG_W-1:0] tag_q, tag_d;
  logic [1:0][PFN_W-1:0] pfn_q, pfn_d;
  tlb_flags_t [1:0]      flg_q, flg_d;
  logic                  tog_q, tog_d;
  logic [1:0]            same;
  logic                  victim, evict, load;

  // Victim choice: matching way, then first invalid way, then toggle.
  always_comb begin
    for (int w = 0; w < 2; w++) same[w] = v_q[w] && (tag_q[w] == wr_tag_i);
    evict = 1'b0;
    if (same[0])      victim = 1'b0;
    else if (same[1]) victim = 1'b1;
    else if (!v_q[0]) victim = 1'b0;
    else if (!v_q[1]) victim = 1'b1;
    else begin
      victim = tog_q;
      evict  = 1'b1;
    end
  end

  // Set contents after flush and refill, as seen by a lookup this cycle.
  always_comb begin
    for (int w = 0; w < 2; w++) begin
      if (flush_i) begin
        view_v_o[w]     = 1'b0;
        view_tag_o[w]   = tag_q[w];
        view_pfn_o[w]   = pfn_q[w];
        view_flags_o[w] = flg_q[w];
      end else if (wr_en_i && (victim == w[0])) begin
        view_v_o[w]     = 1'b1;
        view_tag_o[w]   = wr_tag_i;
        view_pfn_o[w]   = wr_pfn_i;
        view_flags_o[w] = wr_flags_i;
      end else begin
        view_v_o[w]     = v_q[w];
        view_tag_o[w]   = tag_q[w];
        view_pfn_o[w]   = pfn_q[w];
        view_flags_o[w] = flg_q[w];
      end
    end
  end

  // Next state: view plus the flag update of a permitted hit.
  always_comb begin
    v_d   = view_v_o;
    tag_d = view_tag_o;
    pfn_d = view_pfn_o;
    flg_d = view_flags_o;
    if (upd_en_i) begin
      flg_d[upd_way_i].refd = 1'b1;
      if (upd_dirty_i) flg_d[upd_way_i].dirty = 1'b1;
    end
    tog_d = tog_q ^ (wr_en_i && !flush_i && evict);
    load  = flush_i || wr_en_i || upd_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      tog_q <= 1'b0;
    end else if (load) begin
      v_q   <= v_d;
      tog_q <= tog_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q <= tag_d;
      pfn_q <= pfn_d;
      flg_q <= flg_d;
    end
  end

  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (&v_q) |-> (tag_q[0] != tag_q[1])); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (v_q == 2'b00)); // R8

  AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(tog_q)); // R7

endmodule

// File: rtl/tlb2w_match.sv
module tlb2w_match
  import tlb2w_pkg::*;
#(
  parameter int TAG_W = 14,
  parameter int PFN_W = 42
) (
  input  logic [1:0]            v_i,
  input  logic [1:0][TAG_W-1:0] tag_i,
  input  logic [1:0][PFN_W-1:0] pfn_i,
  input  tlb_flags_t [1:0]      flags_i,
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic                  req_wr_i,
  input  logic                  req_user_i,
  output logic [1:0]            hits_o,
  output logic                  hit_o,
  output logic                  way_o,
  output logic                  ok_o,
  output logic [PFN_W-1:0]      pfn_o,
  output tlb_flags_t            flags_o
);

  // Two comparators, one per way, in the same cycle.
  always_comb begin
    for (int w = 0; w < 2; w++) hits_o[w] = v_i[w] && (tag_i[w] == req_tag_i);
    hit_o   = |hits_o;
    way_o   = hits_o[1];
    pfn_o   = pfn_i[way_o];
    flags_o = flags_i[way_o];
    ok_o    = perm_ok(flags_o, req_wr_i, req_user_i);
  end

endmodule

// File: rtl/tlb2w_top.sv
module tlb2w_top
  import tlb2w_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 42,
  parameter int ENTRIES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             lk_req_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_wr_i,
  input  logic             lk_user_i,
  input  logic             rf_req_i,
  input  logic [VPN_W-1:0] rf_vpn_i,
  input  logic [PFN_W-1:0] rf_pfn_i,
  input  logic [5:0]       rf_flags_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic             prot_fault_o,
  output logic             ref_o,
  output logic             dirty_o,
  output logic             miss_irq_o,
  output logic [VPN_W-1:0] miss_vpn_o
);

  localparam int SETS  = ENTRIES / 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_int <= rst_s1;
    end
  end

  logic [IDX_W-1:0] rf_idx, lk_idx;
  logic [TAG_W-1:0] rf_tag, lk_tag;
  assign rf_idx = rf_vpn_i[IDX_W-1:0];
  assign rf_tag = rf_vpn_i[VPN_W-1:IDX_W];
  assign lk_idx = lk_vpn_i[IDX_W-1:0];
  assign lk_tag = lk_vpn_i[VPN_W-1:IDX_W];

  logic [SETS-1:0][1:0]            all_v;
  logic [SETS-1:0][1:0][TAG_W-1:0] all_tag;
  logic [SETS-1:0][1:0][PFN_W-1:0] all_pfn;
  tlb_flags_t [SETS-1:0][1:0]      all_flg;

  logic [1:0]       m_hits;
  logic             m_hit, m_way, m_ok;
  logic [PFN_W-1:0] m_pfn;
  tlb_flags_t       m_flags;
  logic             upd_any;

  assign upd_any = lk_req_i && m_hit && m_ok;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    tlb2w_set #(.TAG_W(TAG_W), .PFN_W(PFN_W)) set_i (
      .clk          (clk),
      .rst_n        (rst_int),
      .flush_i      (flush_i),
      .wr_en_i      (rf_req_i && (rf_idx == IDX_W'(g))),
      .wr_tag_i     (rf_tag),
      .wr_pfn_i     (rf_pfn_i),
      .wr_flags_i   (tlb_flags_t'(rf_flags_i)),
      .upd_en_i     (upd_any && (lk_idx == IDX_W'(g))),
      .upd_way_i    (m_way),
      .upd_dirty_i  (lk_wr_i),
      .view_v_o     (all_v[g]),
      .view_tag_o   (all_tag[g]),
      .view_pfn_o   (all_pfn[g]),
      .view_flags_o (all_flg[g])
    );
  end

  tlb2w_match #(.TAG_W(TAG_W), .PFN_W(PFN_W)) match_i (
    .v_i        (all_v[lk_idx]),
    .tag_i      (all_tag[lk_idx]),
    .pfn_i      (all_pfn[lk_idx]),
    .flags_i    (all_flg[lk_idx]),
    .req_tag_i  (lk_tag),
    .req_wr_i   (lk_wr_i),
    .req_user_i (lk_user_i),
    .hits_o     (m_hits),
    .hit_o      (m_hit),
    .way_o      (m_way),
    .ok_o       (m_ok),
    .pfn_o      (m_pfn),
    .flags_o    (m_flags)
  );

  logic             hit_d, flt_d, miss_d, ref_d, dty_d;
  logic [PFN_W-1:0] pfn_d;

  always_comb begin
    hit_d  = 1'b0;
    flt_d  = 1'b0;
    miss_d = 1'b0;
    ref_d  = 1'b0;
    dty_d  = 1'b0;
    pfn_d  = '0;
    if (lk_req_i) begin
      if (!m_hit) begin
        miss_d = 1'b1;
      end else begin
        ref_d = m_flags.refd;
        dty_d = m_flags.dirty;
        if (m_ok) begin
          hit_d = 1'b1;
          pfn_d = m_pfn;
        end else begin
          flt_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      hit_o        <= 1'b0;
      prot_fault_o <= 1'b0;
      miss_irq_o   <= 1'b0;
      ref_o        <= 1'b0;
      dirty_o      <= 1'b0;
      pfn_o        <= '0;
    end else begin
      hit_o        <= hit_d;
      prot_fault_o <= flt_d;
      miss_irq_o   <= miss_d;
      ref_o        <= ref_d;
      dirty_o      <= dty_d;
      pfn_o        <= pfn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)    miss_vpn_o <= '0;
    else if (miss_d) miss_vpn_o <= lk_vpn_i;
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_int)
    lk_req_i |=> $onehot({hit_o, prot_fault_o, miss_irq_o})); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int)
    !lk_req_i |=> !(hit_o || prot_fault_o || miss_irq_o)); // R1

  AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int)
    lk_req_i |=> (!miss_irq_o || (miss_vpn_o == $past(lk_vpn_i)))); // R3

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_int)
    !lk_req_i |=> $stable(miss_vpn_o)); // R3

  AST_FAULT_NO_PFN: assert property (@(posedge clk) disable iff (!rst_int)
    prot_fault_o |-> (pfn_o == '0)); // R4

  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_int)
    (flush_i && lk_req_i) |=> miss_irq_o); // R8

  AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_int)
    $onehot0(m_hits)); // R7

endmodule

// File: tb/tlb2w_top_tb_top.sv
module tlb2w_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20;
  localparam int PFN_W = 42;
  localparam int SETS  = 64;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush_i, lk_req_i, lk_wr_i, lk_user_i, rf_req_i;
  logic [VPN_W-1:0] lk_vpn_i, rf_vpn_i;
  logic [PFN_W-1:0] rf_pfn_i;
  logic [5:0]       rf_flags_i;
  logic             hit_o, prot_fault_o, ref_o, dirty_o, miss_irq_o;
  logic [PFN_W-1:0] pfn_o;
  logic [VPN_W-1:0] miss_vpn_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb2w_top dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_req_i(lk_req_i), .lk_vpn_i(lk_vpn_i), .lk_wr_i(lk_wr_i), .lk_user_i(lk_user_i),
    .rf_req_i(rf_req_i), .rf_vpn_i(rf_vpn_i), .rf_pfn_i(rf_pfn_i), .rf_flags_i(rf_flags_i),
    .hit_o(hit_o), .pfn_o(pfn_o), .prot_fault_o(prot_fault_o), .ref_o(ref_o),
    .dirty_o(dirty_o), .miss_irq_o(miss_irq_o), .miss_vpn_o(miss_vpn_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string cur_req = "R10";

  // Behavioural model state.
  bit               m_v   [SETS][2];
  int               m_tag [SETS][2];
  logic [PFN_W-1:0] m_pfn [SETS][2];
  logic [5:0]       m_fl  [SETS][2];
  bit               m_tog [SETS];
  logic             e_hit, e_flt, e_miss, e_ref, e_dty;
  logic [PFN_W-1:0] e_pfn;
  logic [VPN_W-1:0] e_mvpn;

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      m_tog[s] = 0;
      for (int w = 0; w < 2; w++) begin
        m_v[s][w] = 0; m_tag[s][w] = 0; m_pfn[s][w] = '0; m_fl[s][w] = '0;
      end
    end
    e_hit = 0; e_flt = 0; e_miss = 0; e_ref = 0; e_dty = 0; e_pfn = '0; e_mvpn = '0;
  endtask

  function automatic bit allowed(logic [5:0] f, logic wr, logic user);
    if (user) return wr ? f[1] : f[0];
    return wr ? f[3] : f[2];
  endfunction

  task automatic model_step();
    int s, t, w;
    e_hit = 0; e_flt = 0; e_miss = 0; e_ref = 0; e_dty = 0; e_pfn = '0;
    if (flush_i) begin
      for (int a = 0; a < SETS; a++) begin m_v[a][0] = 0; m_v[a][1] = 0; end
    end else if (rf_req_i) begin
      s = int'(rf_vpn_i) % SETS; t = int'(rf_vpn_i) / SETS; w = -1;
      for (int k = 0; k < 2; k++) if (w < 0 && m_v[s][k] && m_tag[s][k] == t) w = k;
      for (int k = 0; k < 2; k++) if (w < 0 && !m_v[s][k]) w = k;
      if (w < 0) begin w = m_tog[s]; m_tog[s] = !m_tog[s]; end
      m_v[s][w] = 1; m_tag[s][w] = t; m_pfn[s][w] = rf_pfn_i; m_fl[s][w] = rf_flags_i;
    end
    if (lk_req_i) begin
      s = int'(lk_vpn_i) % SETS; t = int'(lk_vpn_i) / SETS; w = -1;
      for (int k = 0; k < 2; k++) if (m_v[s][k] && m_tag[s][k] == t) w = k;
      if (w < 0) begin
        e_miss = 1; e_mvpn = lk_vpn_i;
      end else begin
        e_ref = m_fl[s][w][4]; e_dty = m_fl[s][w][5];
        if (allowed(m_fl[s][w], lk_wr_i, lk_user_i)) begin
          e_hit = 1; e_pfn = m_pfn[s][w];
          m_fl[s][w][4] = 1'b1;
          if (lk_wr_i) m_fl[s][w][5] = 1'b1;
        end else begin
          e_flt = 1;
        end
      end
    end
  endtask

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(hit_o == e_hit, cur_req, "hit", 64'(hit_o), 64'(e_hit));
    chk(prot_fault_o == e_flt, cur_req, "fault", 64'(prot_fault_o), 64'(e_flt));
    chk(miss_irq_o == e_miss, cur_req, "miss_irq", 64'(miss_irq_o), 64'(e_miss));
    chk(pfn_o == e_pfn, cur_req, "pfn", 64'(pfn_o), 64'(e_pfn));
    chk(ref_o == e_ref && dirty_o == e_dty, cur_req, "ref/dirty",
        64'({ref_o, dirty_o}), 64'({e_ref, e_dty}));
    chk(miss_vpn_o == e_mvpn, cur_req, "miss_vpn", 64'(miss_vpn_o), 64'(e_mvpn));
  endtask

  task automatic idle_inputs();
    flush_i = 0; lk_req_i = 0; lk_wr_i = 0; lk_user_i = 0; rf_req_i = 0;
    lk_vpn_i = '0; rf_vpn_i = '0; rf_pfn_i = '0; rf_flags_i = '0;
  endtask

  // One clock with the inputs set by the caller; returns at the falling edge.
  task automatic cyc();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  task automatic fill(int vpn, logic [PFN_W-1:0] pfn, logic [5:0] fl);
    rf_req_i = 1; rf_vpn_i = VPN_W'(vpn); rf_pfn_i = pfn; rf_flags_i = fl;
  endtask

  task automatic look(int vpn, bit wr, bit user);
    lk_req_i = 1; lk_vpn_i = VPN_W'(vpn); lk_wr_i = wr; lk_user_i = user;
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 200000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle_inputs();
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    cur_req = "R10";
    chk(!hit_o && !miss_irq_o && !prot_fault_o && miss_vpn_o == '0, "R10", "reset outputs",
        64'({hit_o, miss_irq_o, prot_fault_o}), 64'(0));
    rst_n = 1;
    repeat (4) cyc();
    look(12'o621, 0, 0); cyc();
    chk(miss_irq_o == 1, "R10", "empty after reset", 64'(miss_irq_o), 64'(1));

    // R1 / R2: two pages in one set.
    cur_req = "R2";
    fill(12'o621, 42'h1_2345, 6'b001111); cyc();
    fill(12'o321, 42'h2_ABCD, 6'b001111); cyc();
    look(12'o621, 0, 1); cyc();
    chk(hit_o && pfn_o == 42'h1_2345, "R1", "hit pfn 0o621", 64'(pfn_o), 64'h12345);
    look(12'o321, 0, 0); cyc();
    chk(hit_o && pfn_o == 42'h2_ABCD, "R2", "hit pfn 0o321", 64'(pfn_o), 64'h2ABCD);

    // R3: miss latches page and holds it.
    cur_req = "R3";
    look(12'o2145, 0, 0); cyc();
    chk(miss_irq_o && miss_vpn_o == VPN_W'(12'o2145), "R3", "miss vpn",
        64'(miss_vpn_o), 64'(12'o2145));
    cyc();
    chk(!miss_irq_o && miss_vpn_o == VPN_W'(12'o2145), "R3", "vpn held",
        64'(miss_vpn_o), 64'(12'o2145));

    // R4: permissions (user-read only entry).
    cur_req = "R4";
    fill(12'o1005, 42'h77, 6'b000001); cyc();
    look(12'o1005, 1, 1); cyc();
    chk(prot_fault_o && !hit_o && pfn_o == '0, "R4", "user write fault",
        64'(prot_fault_o), 64'(1));
    look(12'o1005, 0, 0); cyc();
    chk(prot_fault_o, "R4", "kernel read fault", 64'(prot_fault_o), 64'(1));
    look(12'o1005, 0, 1); cyc();
    chk(hit_o && pfn_o == 42'h77, "R4", "user read ok", 64'(pfn_o), 64'h77);

    // R5 / R6: flag updates.
    cur_req = "R5";
    fill(12'o1006, 42'h88, 6'b001111); cyc();
    look(12'o1006, 0, 0); cyc();
    chk(ref_o == 0 && dirty_o == 0, "R5", "fresh flags", 64'({ref_o, dirty_o}), 64'(0));
    look(12'o1006, 0, 0); cyc();
    chk(ref_o == 1 && dirty_o == 0, "R6", "read keeps clean", 64'({ref_o, dirty_o}), 64'(2));
    look(12'o1006, 1, 1); cyc();
    look(12'o1006, 0, 1); cyc();
    chk(dirty_o == 1, "R6", "write sets dirty", 64'(dirty_o), 64'(1));
    look(12'o1005, 1, 1); cyc();
    look(12'o1005, 0, 1); cyc();
    chk(dirty_o == 0, "R6", "fault no dirty", 64'(dirty_o), 64'(0));

    // R7: victim order in set 0o21 (holds 0o621 in way0, 0o321 in way1).
    cur_req = "R7";
    fill(12'o4021, 42'h401, 6'b001111); cyc();
    look(12'o621, 0, 0); cyc();
    chk(miss_irq_o, "R7", "way0 evicted first", 64'(miss_irq_o), 64'(1));
    fill(12'o5021, 42'h501, 6'b001111); cyc();
    look(12'o321, 0, 0); cyc();
    chk(miss_irq_o, "R7", "way1 evicted next", 64'(miss_irq_o), 64'(1));
    fill(12'o4021, 42'h999, 6'b001111); cyc();
    look(12'o5021, 0, 0); cyc();
    chk(hit_o && pfn_o == 42'h501, "R7", "matching rewrite keeps other", 64'(pfn_o), 64'h501);
    look(12'o4021, 0, 0); cyc();
    chk(hit_o && pfn_o == 42'h999, "R7", "matching way rewritten", 64'(pfn_o), 64'h999);

    // R9: refill and lookup on one set in one cycle.
    cur_req = "R9";
    fill(12'o33, 42'h33, 6'b001111); look(12'o33, 0, 0); cyc();
    chk(hit_o && pfn_o == 42'h33, "R9", "refill seen same cycle", 64'(pfn_o), 64'h33);

    // R8: flush drops refill and makes lookup miss.
    cur_req = "R8";
    flush_i = 1; fill(12'o44, 42'h44, 6'b001111); look(12'o33, 0, 0); cyc();
    chk(miss_irq_o, "R8", "lookup misses in flush", 64'(miss_irq_o), 64'(1));
    look(12'o44, 0, 0); cyc();
    chk(miss_irq_o, "R8", "refill dropped", 64'(miss_irq_o), 64'(1));
    look(12'o5021, 0, 0); cyc();
    chk(miss_irq_o, "R8", "all invalid", 64'(miss_irq_o), 64'(1));

    // Random phase against the model (R1..R9 together).
    cur_req = "R1";
    r = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      if (r[31:27] == 0) flush_i = 1;
      if (r[3:2] != 0) look(int'(r[5:4]) * SETS + 5 + int'(r[6]), r[7], r[8]);
      if (r[10:9] == 0) fill(int'(r[12:11]) * SETS + 5 + int'(r[13]),
                             {r[26:14], r[31:3]}, r[21:16]);
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule